// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit for two's-complement words. It is built as a chain of identical one-bit cells, each of which forms an AND, an OR and a full-adder sum of its two operand bits and picks one of them through a shared two-bit path select. The carry leaving every cell enters the cell above it. The topmost cell is a variant that also detects signed overflow and produces the signed less-than indication, which is routed back into the lowest cell.

Subtraction and NOR come only from two inversion controls. One inverts the `a` operand. The other inverts the `b` operand and also supplies the carry into bit 0, so `a + ~b + 1` gives `a - b`, and inverting both operands with the AND path gives NOR. A zero flag covers the whole result, so equality can be tested by subtracting. The controls, read as the word `{inv_a, neg_b, func_sel}`, select the operation.

Top module: `bitslice_alu`

## Requirements
- R1: Control word 0000 (AND) gives `result = opnd_a & opnd_b`.
- R2: Control word 0001 (OR) gives `result = opnd_a | opnd_b`.
- R3: Control word 0010 (add) gives `result = (opnd_a + opnd_b) mod 2^32`, and `cout` equals bit 32 of the unsigned 33-bit sum.
- R4: Control word 0110 (subtract) gives `result = (opnd_a - opnd_b) mod 2^32`, and `cout` is 1 exactly when `opnd_a >= opnd_b` as unsigned values.
- R5: Control word 1100 (NOR) gives `result = ~(opnd_a | opnd_b)`.
- R6: Control word 0111 (set-on-less-than) gives `result = 1` when `opnd_a < opnd_b` as signed values and 0 otherwise. Bits 31..1 are always 0, and the answer stays correct when `opnd_a - opnd_b` overflows.
- R7: `is_zero` is 1 exactly when all 32 result bits are 0. Subtracting equal operands therefore gives `is_zero = 1`.
- R8: In add mode, `ovf` is 1 exactly when both operands have the same sign bit and the result sign differs from it. Operands of opposite sign never overflow.
- R9: In subtract and set-on-less-than modes, `ovf` is 1 exactly when the operand signs differ and the sign of `opnd_a - opnd_b` differs from the sign of `opnd_a`.
- R10: The block holds no state. All outputs follow the present inputs within the cycle in which those inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| inv_a | input | 1 | Invert `opnd_a` before every path |
| neg_b | input | 1 | Invert `opnd_b` and set the carry into bit 0 |
| func_sel | input | 2 | Path select: 00 AND, 01 OR, 10 sum, 11 less-than |
| result | output | 32 | Selected result word |
| is_zero | output | 1 | High when every result bit is 0 |
| ovf | output | 1 | Signed overflow (arithmetic modes only) |
| cout | output | 1 | Carry out of the top cell |

## Verification
No result needs a clock edge to appear. Result, zero flag, overflow and carry are all due in the same cycle that the operands and controls are applied. The driver applies each stimulus on a rising edge and queues the expected values. The monitor pops and compares them on the following falling edge, half a period later, which leaves the whole ripple chain time to settle before any output is read. Overflow and carry are compared only for add, subtract and set-on-less-than. In logic modes those flags carry no defined meaning.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int unsigned SEL_W = 2;
    localparam int unsigned CTL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        PATH_AND  = 2'b00,
        PATH_OR   = 2'b01,
        PATH_SUM  = 2'b10,
        PATH_LESS = 2'b11
    } path_sel_e;

    typedef struct packed {
        logic a_eff;
        logic b_eff;
        logic sum;
        logic carry;
        logic res;
    } cell_t;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic             a_i,
    input  logic             b_i,
    input  logic             a_inv_i,
    input  logic             b_inv_i,
    input  logic             carry_i,
    input  logic             less_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             res_o,
    output logic             carry_o
);
    cell_t cell_d;

    always_comb begin
        cell_d       = '0;
        cell_d.a_eff = a_i ^ a_inv_i;
        cell_d.b_eff = b_i ^ b_inv_i;
        cell_d.sum   = cell_d.a_eff ^ cell_d.b_eff ^ carry_i;
        cell_d.carry = (cell_d.a_eff & cell_d.b_eff)
                     | (cell_d.a_eff & carry_i)
                     | (cell_d.b_eff & carry_i);
        case (path_sel_e'(sel_i))
            PATH_AND:  cell_d.res = cell_d.a_eff & cell_d.b_eff;
            PATH_OR:   cell_d.res = cell_d.a_eff | cell_d.b_eff;
            PATH_SUM:  cell_d.res = cell_d.sum;
            default:   cell_d.res = less_i;
        endcase
    end

    assign res_o   = cell_d.res;
    assign carry_o = cell_d.carry;
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic             a_i,
    input  logic             b_i,
    input  logic             a_inv_i,
    input  logic             b_inv_i,
    input  logic             carry_i,
    input  logic             less_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             res_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             set_o
);
    logic a_eff_d;
    logic b_eff_d;
    logic sum_d;
    logic ovf_d;

    alu_slice u_cell (
        .a_i     (a_i),
        .b_i     (b_i),
        .a_inv_i (a_inv_i),
        .b_inv_i (b_inv_i),
        .carry_i (carry_i),
        .less_i  (less_i),
        .sel_i   (sel_i),
        .res_o   (res_o),
        .carry_o (carry_o)
    );

    // Sign rule: like-signed effective operands whose sum changes sign.
    always_comb begin
        a_eff_d = a_i ^ a_inv_i;
        b_eff_d = b_i ^ b_inv_i;
        sum_d   = a_eff_d ^ b_eff_d ^ carry_i;
        ovf_d   = (a_eff_d == b_eff_d) && (sum_d != a_eff_d);
    end

    assign ovf_o = ovf_d;
    // Raw sign corrected by overflow keeps the comparison exact.
    assign set_o = sum_d ^ ovf_d;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);
    logic zero_d;

    always_comb begin
        zero_d = 1'b1;
        for (int i = 0; i < int'(WIDTH); i++) begin
            zero_d = zero_d & ~word_i[i];
        end
    end

    assign zero_o = zero_d;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             inv_a,
    input  logic             neg_b,
    input  logic [1:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             ovf,
    output logic             cout
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0]   carry_d;
    logic [WIDTH-1:0] res_d;
    logic             set_d;
    logic             ovf_d;

    assign carry_d[0] = neg_b;

    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_cell
        logic less_d;
        if (i == 0) begin : g_lsb
            assign less_d = set_d;
        end else begin : g_upper
            assign less_d = 1'b0;
        end

        if (i == int'(MSB)) begin : g_top
            alu_msb_slice u_slice (
                .a_i     (opnd_a[i]),
                .b_i     (opnd_b[i]),
                .a_inv_i (inv_a),
                .b_inv_i (neg_b),
                .carry_i (carry_d[i]),
                .less_i  (less_d),
                .sel_i   (func_sel),
                .res_o   (res_d[i]),
                .carry_o (carry_d[i+1]),
                .ovf_o   (ovf_d),
                .set_o   (set_d)
            );
        end else begin : g_plain
            alu_slice u_slice (
                .a_i     (opnd_a[i]),
                .b_i     (opnd_b[i]),
                .a_inv_i (inv_a),
                .b_inv_i (neg_b),
                .carry_i (carry_d[i]),
                .less_i  (less_d),
                .sel_i   (func_sel),
                .res_o   (res_d[i]),
                .carry_o (carry_d[i+1])
            );
        end
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i (res_d),
        .zero_o (is_zero)
    );

    assign result = res_d;
    assign ovf    = ovf_d;
    assign cout   = carry_d[WIDTH];
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             inv_a,
    input logic             neg_b,
    input logic [1:0]       func_sel,
    input logic [WIDTH-1:0] result,
    input logic             is_zero,
    input logic             ovf
);
    localparam int unsigned MSB = WIDTH - 1;
    logic [3:0] ctl;
    assign ctl = {inv_a, neg_b, func_sel};

    always_comb begin
        if (ctl == 4'b0000) begin
            p_and_r1: assert (result == (opnd_a & opnd_b))
                else $error("p_and_r1 violated");
        end
        if (ctl == 4'b1100) begin
            p_nor_r5: assert (result == ~(opnd_a | opnd_b))
                else $error("p_nor_r5 violated");
        end
        if (ctl == 4'b0110) begin
            p_sub_r4: assert (result == WIDTH'(opnd_a - opnd_b))
                else $error("p_sub_r4 violated");
        end
        if (ctl == 4'b0111) begin
            p_slt_upper_r6: assert (result[MSB:1] == '0)
                else $error("p_slt_upper_r6 violated");
        end
        if (ctl == 4'b0110 && opnd_a == opnd_b) begin
            p_eq_zero_r7: assert (is_zero && result == '0)
                else $error("p_eq_zero_r7 violated");
        end
        if (ctl == 4'b0010 && opnd_a[MSB] != opnd_b[MSB]) begin
            p_no_overflow_r8: assert (!ovf)
                else $error("p_no_overflow_r8 violated");
        end
    end
endmodule

bind bitslice_alu alu_checker #(.WIDTH(WIDTH)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .inv_a    (inv_a),
    .neg_b    (neg_b),
    .func_sel (func_sel),
    .result   (result),
    .is_zero  (is_zero),
    .ovf      (ovf)
);

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;
    localparam int PERIOD = 10;
    localparam logic [3:0] C_AND = 4'b0000;
    localparam logic [3:0] C_OR  = 4'b0001;
    localparam logic [3:0] C_ADD = 4'b0010;
    localparam logic [3:0] C_SUB = 4'b0110;
    localparam logic [3:0] C_SLT = 4'b0111;
    localparam logic [3:0] C_NOR = 4'b1100;

    typedef struct {
        logic [31:0] res;
        logic        zero;
        logic        ovf;
        logic        cout;
        logic        arith;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  ctl = C_AND;
    logic [31:0] result;
    logic        is_zero, ovf, cout;
    int          checks = 0;
    int          failures = 0;
    exp_t        sb_q[$];

    always #(PERIOD/2) clk = ~clk;

    bitslice_alu u0 (
        .opnd_a   (a),
        .opnd_b   (b),
        .inv_a    (ctl[3]),
        .neg_b    (ctl[2]),
        .func_sel (ctl[1:0]),
        .result   (result),
        .is_zero  (is_zero),
        .ovf      (ovf),
        .cout     (cout)
    );

    function automatic exp_t model(logic [31:0] x, logic [31:0] y,
                                   logic [3:0] c, string tag);
        exp_t e;
        logic [32:0] s;
        e.tag = tag; e.ovf = 1'b0; e.cout = 1'b0; e.arith = 1'b0;
        case (c)
            C_AND: e.res = x & y;
            C_OR:  e.res = x | y;
            C_NOR: e.res = ~(x | y);
            C_ADD: begin
                s = {1'b0, x} + {1'b0, y};
                e.res = s[31:0]; e.cout = s[32]; e.arith = 1'b1;
                e.ovf = (x[31] == y[31]) && (s[31] != x[31]);
            end
            default: begin
                s = {1'b0, x} + {1'b0, ~y} + 33'd1;
                e.cout = s[32]; e.arith = 1'b1;
                e.ovf = (x[31] != y[31]) && (s[31] != x[31]);
                if (c == C_SLT) e.res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
                else            e.res = s[31:0];
            end
        endcase
        e.zero = (e.res == 32'd0);
        return e;
    endfunction

    task automatic drive(logic [31:0] x, logic [31:0] y, logic [3:0] c, string tag);
        @(posedge clk);
        a = x; b = y; ctl = c;
        sb_q.push_back(model(x, y, c, tag));
    endtask

    task automatic check1(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: results are due half a period after each drive edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check1(e.tag, "result", result, e.res);
                check1({e.tag, "/R7"}, "is_zero", {31'd0, is_zero}, {31'd0, e.zero});
                if (e.arith) begin
                    check1(e.tag, "ovf", {31'd0, ovf}, {31'd0, e.ovf});
                    check1(e.tag, "cout", {31'd0, cout}, {31'd0, e.cout});
                end
            end
        end
    end

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Reset state: zero operands in AND mode, R7 and R10.
        repeat (2) @(posedge clk);
        #1;
        check1("R10", "reset result", result, 32'd0);
        check1("R7", "reset is_zero", {31'd0, is_zero}, 32'd1);
        rst = 1'b0;

        drive(32'hF0F0_1234, 32'h0FF0_FF00, C_AND, "R1");
        drive(32'hF0F0_1234, 32'h0FF0_FF00, C_OR,  "R2");
        drive(32'hF0F0_1234, 32'h0FF0_FF00, C_NOR, "R5");
        drive(32'h0000_0000, 32'h0000_0000, C_NOR, "R5");
        drive(32'h7FFF_FFFF, 32'h0000_0001, C_ADD, "R3/R8");
        drive(32'h8000_0000, 32'hFFFF_FFFF, C_ADD, "R3/R8");
        drive(32'hFFFF_FFFF, 32'h0000_0001, C_ADD, "R3/R7");
        drive(32'h7FFF_FFFF, 32'h8000_0000, C_ADD, "R8");
        drive(32'h0000_0007, 32'h0000_0006, C_SUB, "R4");
        drive(32'h0000_0006, 32'h0000_0007, C_SUB, "R4");
        drive(32'h1234_5678, 32'h1234_5678, C_SUB, "R4/R7");
        drive(32'h8000_0000, 32'h0000_0001, C_SUB, "R9");
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, C_SUB, "R9");
        drive(32'h8000_0000, 32'h0000_0001, C_SLT, "R6/R9");
        drive(32'h7FFF_FFFF, 32'h8000_0000, C_SLT, "R6/R9");
        drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, C_SLT, "R6");
        drive(32'h0000_0005, 32'h0000_0005, C_SLT, "R6/R7");
        drive(32'h0000_0003, 32'h0000_0009, C_SLT, "R6");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = (i % 7 == 0) ? x : $urandom();
            case (i % 6)
                0: drive(x, y, C_AND, "R1");
                1: drive(x, y, C_OR,  "R2");
                2: drive(x, y, C_ADD, "R3/R8");
                3: drive(x, y, C_SUB, "R4/R9");
                4: drive(x, y, C_SLT, "R6");
                default: drive(x, y, C_NOR, "R5");
            endcase
        end
        @(posedge clk);
        @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule